// File: doc/BRIEF.md
# Four-Residue Weighted-Value Combiner

This block is the combinational front stage of a residue-to-binary converter. It works on four residues taken against the moduli P1 = 2^(2n+1)-1, P2 = 2^n+1, P3 = 2^(n/2)-1 and P4 = 2^(n/2)+1, where n is an even parameter. It returns the single integer Z in 0 .. P1·P2·P3·P4-1 that has those residues. A later stage combines Z with a power-of-two modulus. That later stage, and forward conversion, lie outside this block.

The product P2·P3·P4 equals 2^(2n)-1, so all intermediate arithmetic runs modulo a Mersenne-form number. P1 is congruent to 1 under that modulus, and the other two scaling inverses reduce to powers of two, which are found at elaboration time. Each scaled difference therefore becomes a set of rotated and complemented copies of the input residues. Ten such 2n-bit words pass through a chain of carry-save stages whose carries wrap from the top bit into bit 0. One modular adder then folds the result into the mixed digit Y in 0 .. 2^(2n)-2. The output is formed as Z = {Y, x1} - Y, which equals x1 + P1·Y.

Top module: `rns4_crt_combiner`

## Requirements
- R1: For valid residues, Z mod (2^(2n+1)-1) equals res1_i.
- R2: For valid residues, Z mod (2^n+1) equals res2_i.
- R3: For valid residues, Z mod (2^(n/2)-1) equals res3_i.
- R4: For valid residues, Z mod (2^(n/2)+1) equals res4_i.
- R5: Z is always below P1·P2·P3·P4. The internal digit Y never takes the all-ones value 2^(2n)-1; that value is replaced by zero.
- R6: When all four residues are zero, Z is zero.
- R7: When the residues are those of an integer X in 0 .. P1·P2·P3·P4-1, Z equals X. This includes X = P1·P2·P3·P4-1, where every residue is at its maximum.
- R8: The top legal residue values are reconstructed correctly: res2_i = 2^n, which sets only bit n, and res4_i = 2^(n/2), which sets only bit n/2.
- R9: The output depends only on the present inputs. It takes no clock and holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| res1_i | input | 2n+1 | residue modulo 2^(2n+1)-1 |
| res2_i | input | n+1 | residue modulo 2^n+1 |
| res3_i | input | n/2 | residue modulo 2^(n/2)-1 |
| res4_i | input | n/2+1 | residue modulo 2^(n/2)+1 |
| z_o | output | 4n+1 | reconstructed weighted value |

## Verification
Two effects can occur in the same evaluation, and they interact. The end-around carry of the carry-save chain and the final fold can produce the all-ones pattern, which must then be forced to zero. At the same moment, the top bit of res4_i can wrap around through the rotation into bit 0. The residue sets of X = M-1, of X just below and at multiples of P1, and of X whose res4_i equals 2^(n/2) drive both effects together. Each result is judged by comparing Z with X exactly and by recomputing all four residues of Z in the bench.

// File: rtl/rns4_pkg.sv
`timescale 1ns/1ps
package rns4_pkg;

  localparam int RNS4_NUM_OPS = 10;

  function automatic longint unsigned p1_of(input int n);
    return (64'd1 << (2*n + 1)) - 64'd1;
  endfunction

  function automatic longint unsigned p2_of(input int n);
    return (64'd1 << n) + 64'd1;
  endfunction

  function automatic longint unsigned p3_of(input int n);
    return (64'd1 << (n/2)) - 64'd1;
  endfunction

  function automatic longint unsigned p4_of(input int n);
    return (64'd1 << (n/2)) + 64'd1;
  endfunction

  // Exponent e < span with (a * 2^e) mod m == 1, or -1 if the inverse is no power of two.
  function automatic int pow2_inv_exp(input longint unsigned a,
                                      input longint unsigned m,
                                      input int span);
    longint unsigned base;
    int found;
    base  = a % m;
    found = -1;
    for (int e = span - 1; e >= 0; e--) begin
      if (((base << e) % m) == 64'd1) found = e;
    end
    return found;
  endfunction

endpackage

// File: rtl/rns4_eac_csa.sv
`timescale 1ns/1ps
module rns4_eac_csa #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);

  logic [W-1:0] maj_w;

  always_comb begin
    sum_o = a_i ^ b_i ^ c_i;
    maj_w = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    // carry weight 2^W is congruent to 1 modulo 2^W-1: wrap into bit 0
    cry_o = {maj_w[W-2:0], maj_w[W-1]};
  end

endmodule

// File: rtl/rns4_csa_chain.sv
`timescale 1ns/1ps
module rns4_csa_chain #(
  parameter int W       = 8,
  parameter int NUM_OPS = 10
) (
  input  logic [W-1:0] ops_i [NUM_OPS],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);

  localparam int STAGES = NUM_OPS - 2;

  logic [W-1:0] s_w [STAGES+1];
  logic [W-1:0] c_w [STAGES+1];

  assign s_w[0] = ops_i[0];
  assign c_w[0] = ops_i[1];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    rns4_eac_csa #(.W(W)) u_csa (
      .a_i   (s_w[g]),
      .b_i   (c_w[g]),
      .c_i   (ops_i[g+2]),
      .sum_o (s_w[g+1]),
      .cry_o (c_w[g+1])
    );
  end

  assign sum_o = s_w[STAGES];
  assign cry_o = c_w[STAGES];

endmodule

// File: rtl/rns4_mersenne_add.sv
`timescale 1ns/1ps
module rns4_mersenne_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);

  logic [W:0]   raw_w;
  logic [W-1:0] fold_w;

  always_comb begin
    raw_w  = {1'b0, a_i} + {1'b0, b_i};
    // raw < 2^(W+1)-1, so adding the carry back cannot overflow again
    fold_w = raw_w[W-1:0] + {{(W-1){1'b0}}, raw_w[W]};
    y_o    = (&fold_w) ? '0 : fold_w;
  end

endmodule

// File: rtl/rns4_operand_gen.sv
`timescale 1ns/1ps
module rns4_operand_gen #(
  parameter int N  = 4,
  parameter int E2 = 3,
  parameter int E3 = 0
) (
  input  logic [2*N:0]   res1_i,
  input  logic [N:0]     res2_i,
  input  logic [N/2-1:0] res3_i,
  input  logic [N/2:0]   res4_i,
  output logic [2*N-1:0] ops_o [rns4_pkg::RNS4_NUM_OPS]
);

  localparam int W   = 2 * N;
  localparam int H   = N / 2;
  localparam int SH2 = (E2 + N) % W;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int s);
    return (v << s) | (v >> (W - s));
  endfunction

  logic [W-1:0] x2_pad;
  logic [W-1:0] x4_pad;
  logic [W-1:0] x3_even;
  logic [W-1:0] x3_odd;
  logic [W-1:0] x4_plus;
  logic [W-1:0] x4_minus;

  always_comb begin
    x2_pad   = {{(W-N-1){1'b0}}, res2_i};
    x4_pad   = {{(W-H-1){1'b0}}, res4_i};
    // copies of res3 at offsets 0 and n, and at n/2 and 3n/2 (no overlap)
    x3_even  = {{H{1'b0}}, res3_i, {H{1'b0}}, res3_i};
    x3_odd   = {res3_i, {H{1'b0}}, res3_i, {H{1'b0}}};
    // copies of res4 at n/2 and 3n/2 (top bit wraps to bit 0), at 0 and n
    x4_plus  = rotl(x4_pad, H) | rotl(x4_pad, 3*H);
    x4_minus = x4_pad | rotl(x4_pad, N);

    // difference res2 - res1, inverse 1
    ops_o[0] = x2_pad;
    ops_o[1] = ~res1_i[W-1:0];
    ops_o[2] = ~{{(W-1){1'b0}}, res1_i[W]};
    // P2 * 2^E2 * (res3 - res2)
    ops_o[3] = ~rotl(x2_pad, E2);
    ops_o[4] = ~rotl(x2_pad, SH2);
    ops_o[5] = rotl(x3_even, E2);
    // P2*P3 * 2^E3 * (res4 - res3), P2*P3 = 2^(3n/2) - 2^n + 2^(n/2) - 1
    ops_o[6] = rotl(x3_even, E3);
    ops_o[7] = ~rotl(x3_odd, E3);
    ops_o[8] = rotl(x4_plus, E3);
    ops_o[9] = ~rotl(x4_minus, E3);
  end

endmodule

// File: rtl/rns4_crt_combiner.sv
`timescale 1ns/1ps
module rns4_crt_combiner #(
  parameter int N = 4
) (
  input  logic [2*N:0]   res1_i,
  input  logic [N:0]     res2_i,
  input  logic [N/2-1:0] res3_i,
  input  logic [N/2:0]   res4_i,
  output logic [4*N:0]   z_o
);

  localparam int W    = 2 * N;
  localparam int ZW   = 4 * N + 1;
  localparam int NOPS = rns4_pkg::RNS4_NUM_OPS;

  localparam longint unsigned P1 = rns4_pkg::p1_of(N);
  localparam longint unsigned P2 = rns4_pkg::p2_of(N);
  localparam longint unsigned P3 = rns4_pkg::p3_of(N);
  localparam longint unsigned P4 = rns4_pkg::p4_of(N);

  localparam int E2 = rns4_pkg::pow2_inv_exp((P1 * P2) % (P3 * P4), P3 * P4, N);
  localparam int E3 = rns4_pkg::pow2_inv_exp((P1 * P2 * P3) % P4, P4, N);

  if ((N % 2) != 0 || N < 4 || N > 16) begin : g_bad_n
    $error("rns4_crt_combiner: N must be even and within 4..16");
  end
  if (E2 < 0 || E3 < 0) begin : g_bad_inv
    $error("rns4_crt_combiner: scaling inverse is not a power of two");
  end

  logic [W-1:0] ops_w [NOPS];
  logic [W-1:0] sum_w;
  logic [W-1:0] cry_w;
  logic [W-1:0] y_w;

  rns4_operand_gen #(.N(N), .E2(E2 < 0 ? 0 : E2), .E3(E3 < 0 ? 0 : E3)) u_ops (
    .res1_i (res1_i),
    .res2_i (res2_i),
    .res3_i (res3_i),
    .res4_i (res4_i),
    .ops_o  (ops_w)
  );

  rns4_csa_chain #(.W(W), .NUM_OPS(NOPS)) u_chain (
    .ops_i (ops_w),
    .sum_o (sum_w),
    .cry_o (cry_w)
  );

  rns4_mersenne_add #(.W(W)) u_fold (
    .a_i (sum_w),
    .b_i (cry_w),
    .y_o (y_w)
  );

  // x1 + P1*Y = Y*2^(2n+1) + x1 - Y
  assign z_o = {y_w, res1_i} - {{(ZW-W){1'b0}}, y_w};

endmodule

// File: rtl/rns4_crt_combiner_chk.sv
`timescale 1ns/1ps
module rns4_crt_combiner_chk #(
  parameter int N = 4
) (
  input logic [2*N:0]   res1_i,
  input logic [N:0]     res2_i,
  input logic [N/2-1:0] res3_i,
  input logic [N/2:0]   res4_i,
  input logic [4*N:0]   z_i,
  input logic [2*N-1:0] y_i
);

  localparam longint unsigned P1 = rns4_pkg::p1_of(N);
  localparam longint unsigned P2 = rns4_pkg::p2_of(N);
  localparam longint unsigned P3 = rns4_pkg::p3_of(N);
  localparam longint unsigned P4 = rns4_pkg::p4_of(N);
  localparam longint unsigned M  = P1 * P2 * P3 * P4;

  logic valid_w;
  logic [63:0] z64;

  always_comb begin
    z64     = 64'(z_i);
    valid_w = (64'(res1_i) < P1) && (64'(res2_i) < P2) &&
              (64'(res3_i) < P3) && (64'(res4_i) < P4);
    if (valid_w) begin
      a_r1_res_p1: assert ((z64 % P1) == 64'(res1_i));
      a_r2_res_p2: assert ((z64 % P2) == 64'(res2_i));
      a_r3_res_p3: assert ((z64 % P3) == 64'(res3_i));
      a_r4_res_p4: assert ((z64 % P4) == 64'(res4_i));
      a_r5_z_range: assert (z64 < M);
      a_r5_y_canon: assert (!(&y_i));
      if (res1_i == '0 && res2_i == '0 && res3_i == '0 && res4_i == '0) begin
        a_r6_zero: assert (z_i == '0);
      end
    end
  end

endmodule

bind rns4_crt_combiner rns4_crt_combiner_chk #(.N(N)) u_chk (
  .res1_i (res1_i),
  .res2_i (res2_i),
  .res3_i (res3_i),
  .res4_i (res4_i),
  .z_i    (z_o),
  .y_i    (y_w)
);

// File: tb/test_rns4_crt_combiner.sv
`timescale 1ns/1ps
module test_rns4_crt_combiner;

  localparam int N = 4;
  localparam longint unsigned P1 = (64'd1 << (2*N + 1)) - 64'd1;
  localparam longint unsigned P2 = (64'd1 << N) + 64'd1;
  localparam longint unsigned P3 = (64'd1 << (N/2)) - 64'd1;
  localparam longint unsigned P4 = (64'd1 << (N/2)) + 64'd1;
  localparam longint unsigned M  = P1 * P2 * P3 * P4;
  localparam int NVEC = 16;
  localparam int WD_CYCLES = 50000;

  localparam longint unsigned VEC [NVEC] = '{
    64'd0, 64'd1, 64'd2, 64'd510, 64'd511, 64'd512, 64'd16, 64'd17,
    64'd255, 64'd256, 64'd4095, 64'd65535, 64'd65536, 64'd99999,
    64'd130303, 64'd130304
  };

  logic clk;
  logic rst_n;
  logic [2*N:0]   res1;
  logic [N:0]     res2;
  logic [N/2-1:0] res3;
  logic [N/2:0]   res4;
  logic [4*N:0]   z;

  int n_cmp;
  int n_bad;
  bit done;

  rns4_crt_combiner #(.N(N)) i_rns4_crt_combiner (
    .res1_i (res1),
    .res2_i (res2),
    .res3_i (res3),
    .res4_i (res4),
    .z_o    (z)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input longint unsigned a, input longint unsigned b,
                       input longint unsigned c, input longint unsigned d);
    @(negedge clk);
    res1 = (2*N+1)'(a);
    res2 = (N+1)'(b);
    res3 = (N/2)'(c);
    res4 = (N/2+1)'(d);
    @(posedge clk);
    #2;
  endtask

  task automatic check_residues(input longint unsigned a, input longint unsigned b,
                                input longint unsigned c, input longint unsigned d);
    longint unsigned zv;
    zv = 64'(z);
    chk("R1 z mod P1", zv % P1, a);
    chk("R2 z mod P2", zv % P2, b);
    chk("R3 z mod P3", zv % P3, c);
    chk("R4 z mod P4", zv % P4, d);
    chk("R5 z below M", (zv < M) ? 64'd1 : 64'd0, 64'd1);
  endtask

  task automatic run_value(input longint unsigned x);
    drive(x % P1, x % P2, x % P3, x % P4);
    check_residues(x % P1, x % P2, x % P3, x % P4);
    chk("R7 z equals x", 64'(z), x);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    res1 = '0;
    res2 = '0;
    res3 = '0;
    res4 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: all-zero residues at start-up
    @(posedge clk);
    #2;
    chk("R6 zero residues", 64'(z), 64'd0);

    // vector table, reduced into range
    for (int i = 0; i < NVEC; i++) begin
      run_value(VEC[i] % M);
    end

    // R7: maximum value, every residue at Pi-1
    run_value(M - 64'd1);
    chk("R7 max residue set", 64'(z), M - 64'd1);

    // R8: res2 = 2^n alone (bit n only)
    drive(0, 64'd1 << N, 0, 0);
    check_residues(0, 64'd1 << N, 0, 0);
    // R8: res4 = 2^(n/2) alone (bit n/2 only)
    drive(0, 0, 0, 64'd1 << (N/2));
    check_residues(0, 0, 0, 64'd1 << (N/2));
    // R8: both top values together with res1 at its maximum
    drive(P1 - 1, 64'd1 << N, 0, 64'd1 << (N/2));
    check_residues(P1 - 1, 64'd1 << N, 0, 64'd1 << (N/2));

    // R6 again after non-zero traffic
    drive(0, 0, 0, 0);
    chk("R6 zero after traffic", 64'(z), 64'd0);

    // R9: output follows inputs with no clock edge in between
    @(negedge clk);
    res1 = (2*N+1)'(64'd1000 % P1);
    res2 = (N+1)'(64'd1000 % P2);
    res3 = (N/2)'(64'd1000 % P3);
    res4 = (N/2+1)'(64'd1000 % P4);
    #1;
    chk("R9 no clock needed", 64'(z), 64'd1000);

    // random sweep
    for (int k = 0; k < 400; k++) begin
      longint unsigned x;
      x = {32'($urandom), 32'($urandom)} % M;
      run_value(x);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule